// File: doc/BRIEF.md
# Converter Serial Port Controller

This block holds the digital serial port and the sequencing for a four-channel converter whose resolution can be lowered. A host drives a serial clock and a two-bit channel select. While the block sleeps, a high-to-low serial clock transition wakes it, captures the channel and opens a trim window. The window is a fixed number of system clocks long. Each further serial clock fall inside the window removes one bit of resolution, and no more than six bits can be removed. When the window closes, the block asks the conversion engine for a result on the captured channel at the trimmed resolution.

The serial data line carries two meanings. From the waking edge until the result has been loaded, it stays low and acts as a busy flag. After the engine reports done, each serial clock fall presents the next result bit, MSB first. After the last bit, the next serial clock rise pulls the line low and sends the block back to sleep. The serial clock and the channel select are synchronized through a two-flop chain, and their edges are detected in the system clock domain.

Top module: `cvt_sport_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block to sleep. After reset `sdata_out` is 0, `eng_start` is 0, the trim count is cleared, and a pending window is abandoned.
- R2: A serial clock fall while asleep wakes the block. The same fall captures `chan_sel_in`, and the captured code appears on `eng_chan` unchanged: 2'b00 selects channel 1, 2'b01 channel 2, 2'b10 channel 3 and 2'b11 channel 4. Later changes on `chan_sel_in` have no effect.
- R3: Each further serial clock fall within the `WIN_CYC`-cycle window that follows the wake removes one bit. `eng_res` equals 16 minus the number of removed bits.
- R4: No more than six bits are removed. Falls beyond the sixth inside the window leave `eng_res` at 10.
- R5: When the window closes, `eng_start` goes high for exactly one system clock, and `eng_chan` and `eng_res` already hold their final values.
- R6: `sdata_out` stays 0 from the waking fall until the first serial clock fall after `eng_done`.
- R7: After `eng_done` loads `eng_result`, each serial clock fall drives the next bit of `eng_result[eng_res-1:0]` on `sdata_out`, MSB first. Result bits at or above `eng_res` are ignored, and so are changes to `eng_result` after the load.
- R8: Exactly `eng_res` bits are shifted out. The serial clock rise that follows the last bit returns `sdata_out` to 0 and puts the block back to sleep, so the next fall starts a new conversion.
- R9: Serial clock falls that arrive after the window closes but before the result is loaded are ignored. They change neither `eng_res` nor the shifted bits.
- R10: `sdata_out` is always driven to a known 0 or 1 and is never high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Host serial clock, asynchronous, idles high |
| chan_sel_in | input | 2 | Host channel select, captured on the waking fall |
| sdata_out | output | 1 | Busy flag / serial result, push-pull |
| eng_start | output | 1 | One-cycle request to the conversion engine |
| eng_chan | output | 2 | Captured channel code for the engine |
| eng_res | output | $clog2(RES_FULL+1) | Requested resolution in bits |
| eng_done | input | 1 | Engine result valid, one cycle |
| eng_result | input | RES_FULL | Engine result, right-aligned at `eng_res` bits |

## Verification
The assertions assume three things about the inputs. `eng_done` arrives only after `eng_start`, while the block waits for it. Each level of the serial clock lasts several system clocks, so every edge is seen by the synchronizer. The channel select is stable around the waking fall. The bench drives every serial clock phase for five system clocks and holds the channel select for two cycles before the waking fall. Its engine model answers only after it has seen `eng_start`. It places trim edges well inside the window and sends late edges only after the start request.

// File: rtl/cvt_sport_pkg.sv
package cvt_sport_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP   = 2'd0,
    ST_WINDOW  = 2'd1,
    ST_CONVERT = 2'd2,
    ST_SHIFT   = 2'd3
  } sport_state_e;

  // resolution actually delivered after trimming
  function automatic int unsigned delivered_res(int unsigned full, int unsigned cut);
    return full - cut;
  endfunction

endpackage

// File: rtl/cvt_edge_sync.sv
module cvt_edge_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned DW     = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_in,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_q,
  output logic          fall_o,
  output logic          rise_o
);

  logic [STAGES-1:0] pipe_q;
  logic              last_q;
  logic [DW-1:0]     dq [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '1;
      last_q <= 1'b1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], sclk_in};
      last_q <= pipe_q[STAGES-1];
    end
  end

  // channel select follows the same delay as the clock so both line up
  for (genvar g = 0; g < STAGES; g++) begin : g_data
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) dq[g] <= '0;
        else     dq[g] <= data_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) dq[g] <= '0;
        else     dq[g] <= dq[g-1];
      end
    end
  end

  assign data_q = dq[STAGES-1];
  assign fall_o = last_q & ~pipe_q[STAGES-1];
  assign rise_o = ~last_q & pipe_q[STAGES-1];

endmodule

// File: rtl/cvt_trim_window.sv
module cvt_trim_window #(
  parameter int unsigned WIN_CYC = 128,
  parameter int unsigned MAX_CUT = 6,
  localparam int unsigned WIN_W  = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1,
  localparam int unsigned CUT_W  = $clog2(MAX_CUT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic             fall_i,
  output logic             open_o,
  output logic             close_o,
  output logic [CUT_W-1:0] cut_o
);

  logic [WIN_W-1:0] cnt_q;
  logic             open_q;
  logic [CUT_W-1:0] cut_q;
  logic             cut_full;

  assign cut_full = (cut_q == CUT_W'(MAX_CUT));
  assign close_o  = open_q && (cnt_q == WIN_W'(WIN_CYC - 1));
  assign open_o   = open_q;
  assign cut_o    = cut_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
      cut_q  <= '0;
    end else if (arm_i) begin
      cnt_q  <= '0;
      open_q <= 1'b1;
      cut_q  <= '0;
    end else if (open_q) begin
      if (close_o) open_q <= 1'b0;
      else         cnt_q  <= cnt_q + 1'b1;
      if (fall_i && !cut_full) cut_q <= cut_q + 1'b1;
    end
  end

  // R4
  cut_limit_chk: assert property (@(posedge clk) disable iff (rst)
    cut_q <= CUT_W'(MAX_CUT));

  // R9
  cut_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!open_q && !arm_i) |=> $stable(cut_q));

endmodule

// File: rtl/cvt_shifter.sv
module cvt_shifter #(
  parameter int unsigned W  = 16,
  localparam int unsigned LW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [W-1:0]  data_i,
  input  logic [LW-1:0] len_i,
  input  logic          shift_i,
  input  logic          stop_i,
  output logic          bit_o,
  output logic          empty_o,
  output logic          finish_o
);

  // move the low n bits to the top of the word, clearing the rest
  function automatic logic [W-1:0] left_justify(logic [W-1:0] d, logic [LW-1:0] n);
    logic [W-1:0] mask;
    if (32'(n) >= W) mask = '1;
    else             mask = (W'(1) << n) - W'(1);
    return (d & mask) << (W - 32'(n));
  endfunction

  logic [W-1:0]  sh_q;
  logic [LW-1:0] left_q;
  logic          bit_q;

  assign empty_o  = (left_q == '0);
  assign finish_o = stop_i && empty_o;
  assign bit_o    = bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
      bit_q  <= 1'b0;
    end else if (load_i) begin
      sh_q   <= left_justify(data_i, len_i);
      left_q <= len_i;
      bit_q  <= 1'b0;
    end else if (shift_i && !empty_o) begin
      bit_q  <= sh_q[W-1];
      sh_q   <= {sh_q[W-2:0], 1'b0};
      left_q <= left_q - 1'b1;
    end else if (finish_o) begin
      bit_q  <= 1'b0;
    end
  end

  // R8
  left_bound_chk: assert property (@(posedge clk) disable iff (rst)
    32'(left_q) <= W);

  // R7
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_i && !empty_o && !load_i) |=> (left_q == $past(left_q) - 1'b1));

  // R8
  quiet_after_chk: assert property (@(posedge clk) disable iff (rst)
    finish_o |=> !bit_q);

endmodule

// File: rtl/cvt_sport_ctrl.sv
module cvt_sport_ctrl
  import cvt_sport_pkg::*;
#(
  parameter int unsigned RES_FULL    = 16,
  parameter int unsigned MAX_CUT     = 6,
  parameter int unsigned WIN_CYC     = 128,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          sclk_in,
  input  logic [1:0]                    chan_sel_in,
  output logic                          sdata_out,
  output logic                          eng_start,
  output logic [1:0]                    eng_chan,
  output logic [$clog2(RES_FULL+1)-1:0] eng_res,
  input  logic                          eng_done,
  input  logic [RES_FULL-1:0]           eng_result
);

  localparam int unsigned RES_W = $clog2(RES_FULL + 1);
  localparam int unsigned CUT_W = $clog2(MAX_CUT + 1);

  sport_state_e     state_q;
  logic             fall_evt, rise_evt;
  logic [1:0]       chan_sync;
  logic [1:0]       chan_q;
  logic             wake_evt, load_evt, shift_evt, stop_evt, finish_evt;
  logic             win_open, win_close;
  logic [CUT_W-1:0] cut_cnt;
  logic             shift_empty;
  logic             start_q;

  cvt_edge_sync #(.STAGES(SYNC_STAGES), .DW(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .sclk_in (sclk_in),
    .data_in (chan_sel_in),
    .data_q  (chan_sync),
    .fall_o  (fall_evt),
    .rise_o  (rise_evt)
  );

  assign wake_evt  = (state_q == ST_SLEEP)   && fall_evt;
  assign load_evt  = (state_q == ST_CONVERT) && eng_done;
  assign shift_evt = (state_q == ST_SHIFT)   && fall_evt;
  assign stop_evt  = (state_q == ST_SHIFT)   && rise_evt;

  cvt_trim_window #(.WIN_CYC(WIN_CYC), .MAX_CUT(MAX_CUT)) u_win (
    .clk     (clk),
    .rst     (rst),
    .arm_i   (wake_evt),
    .fall_i  (fall_evt),
    .open_o  (win_open),
    .close_o (win_close),
    .cut_o   (cut_cnt)
  );

  assign eng_res = RES_W'(delivered_res(RES_FULL, 32'(cut_cnt)));

  cvt_shifter #(.W(RES_FULL)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load_evt),
    .data_i   (eng_result),
    .len_i    (eng_res),
    .shift_i  (shift_evt),
    .stop_i   (stop_evt),
    .bit_o    (sdata_out),
    .empty_o  (shift_empty),
    .finish_o (finish_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SLEEP;
      chan_q  <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= (state_q == ST_WINDOW) && win_close;
      if (wake_evt) chan_q <= chan_sync;
      unique case (state_q)
        ST_SLEEP:   if (fall_evt)   state_q <= ST_WINDOW;
        ST_WINDOW:  if (win_close)  state_q <= ST_CONVERT;
        ST_CONVERT: if (eng_done)   state_q <= ST_SHIFT;
        ST_SHIFT:   if (finish_evt) state_q <= ST_SLEEP;
        default:                    state_q <= ST_SLEEP;
      endcase
    end
  end

  assign eng_start = start_q;
  assign eng_chan  = chan_q;

  // R2
  wake_chk: assert property (@(posedge clk) disable iff (rst)
    wake_evt |=> (state_q == ST_WINDOW && win_open));

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  // R3
  res_range_chk: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> (32'(eng_res) <= RES_FULL && 32'(eng_res) + MAX_CUT >= RES_FULL));

  // R6
  busy_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WINDOW || state_q == ST_CONVERT) |-> !sdata_out);

  // R8
  sleep_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SHIFT && $past(state_q) == ST_SHIFT && rise_evt && shift_empty) |=> (state_q == ST_SLEEP));

  // R10
  sdata_known_chk: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(sdata_out));

endmodule

// File: tb/cvt_sport_ctrl_tb_top.sv
`timescale 1ns/1ps
module cvt_sport_ctrl_tb_top;

  localparam int HALF = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk_in = 1'b1;
  logic [1:0]  chan_sel = 2'b00;
  logic        sdata_out;
  logic        eng_start;
  logic [1:0]  eng_chan;
  logic [4:0]  eng_res;
  logic        eng_done = 1'b0;
  logic [15:0] eng_result = '0;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cvt_sport_ctrl dut_i (
    .clk         (clk),
    .rst         (rst),
    .sclk_in     (sclk_in),
    .chan_sel_in (chan_sel),
    .sdata_out   (sdata_out),
    .eng_start   (eng_start),
    .eng_chan    (eng_chan),
    .eng_res     (eng_res),
    .eng_done    (eng_done),
    .eng_result  (eng_result)
  );

  function automatic int exp_res(int extra);
    return 16 - ((extra > 6) ? 6 : extra);
  endfunction

  function automatic logic exp_bit(logic [15:0] w, int res, int idx);
    return w[res - 1 - idx];
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_sclk();
    sclk_in = 1'b0; tick(HALF);
    sclk_in = 1'b1; tick(HALF);
  endtask

  task automatic run_conv(logic [1:0] a, int extra, int late);
    int          res;
    int          waited;
    logic [15:0] word;
    res = exp_res(extra);
    chan_sel = a; tick(2);
    sclk_in = 1'b0; tick(HALF);
    check("R6 busy after wake", sdata_out, 0);
    sclk_in = 1'b1; tick(HALF);
    chan_sel = ~a;  // R2 later select changes ignored
    for (int i = 0; i < extra; i++) begin
      pulse_sclk();
      check("R6 busy in window", sdata_out, 0);
    end
    waited = 0;
    while (!eng_start && waited < 400) begin tick(1); waited++; end
    check("R5 start pulse", eng_start, 1);
    check("R2 channel code", eng_chan, a);
    check("R3 R4 resolution", eng_res, res);
    tick(1);
    check("R5 start one cycle", eng_start, 0);
    for (int i = 0; i < late; i++) begin
      pulse_sclk();
      check("R9 late edge busy", sdata_out, 0);
      check("R9 late edge res", eng_res, res);
    end
    word = 16'($urandom);
    eng_result = word; eng_done = 1'b1; tick(1);
    eng_done = 1'b0; eng_result = ~word; tick(HALF);
    check("R6 low until first shift", sdata_out, 0);
    for (int i = 0; i < res; i++) begin
      sclk_in = 1'b0; tick(HALF);
      check("R7 result bit", sdata_out, exp_bit(word, res, i));
      check("R10 known", $isunknown(sdata_out), 0);
      sclk_in = 1'b1; tick(HALF);
    end
    check("R8 low after last bit", sdata_out, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    tick(4);
    check("R1 reset sdata", sdata_out, 0);
    check("R1 reset start", eng_start, 0);
    rst = 1'b0; tick(3);
    check("R1 idle sdata", sdata_out, 0);
    check("R1 idle start", eng_start, 0);

    run_conv(2'b00, 0, 0);
    run_conv(2'b01, 6, 0);
    run_conv(2'b10, 9, 2);
    run_conv(2'b11, 1, 3);

    // R1 reset in the middle of a window abandons it
    sclk_in = 1'b0; tick(HALF); sclk_in = 1'b1; tick(HALF);
    for (int i = 0; i < 3; i++) pulse_sclk();
    rst = 1'b1; tick(3);
    check("R1 mid-window reset sdata", sdata_out, 0);
    check("R1 mid-window reset start", eng_start, 0);
    rst = 1'b0; tick(3);
    for (int i = 0; i < 150; i++) begin
      if (eng_start) check("R1 no start after reset", eng_start, 0);
      tick(1);
    end
    run_conv(2'b00, 0, 0);

    for (int k = 0; k < 12; k++) begin
      run_conv(2'($urandom), int'($urandom % 10), int'($urandom % 3));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule